// File: doc/BRIEF.md
# Dual-Rail Soft-Start Protection Sequencer

This block sequences the start-up of a paired positive and negative supply and recovers it after a short. It reads comparator flags only. These are the enable, two input-supply flags that form an undervoltage lockout with hysteresis, two temperature flags that form a thermal shutdown with hysteresis, and three rail-threshold flags. From these it selects a current limit for each switching stage and for the linear post-regulator. It also drives the post-regulator enable.

All flags arrive from analog comparators and are synchronised before use. The machine has four stages: off, ramp, hold and run. In ramp, both switchers run at a reduced limit and the post-regulator is off. In hold, the post-regulator is on at its intermediate limit and both switchers move to their intermediate limits. In run, every limit is full. Hold begins when the negative rail reaches its start threshold, which is about -0.4 V. Run begins when the positive rail is at least about 3 V and the negative rail is at or below about -1 V.

When a short collapses a rail, the machine steps back by itself. A short between the two rails makes it alternate between ramp and hold. Each limit field is two bits: 00 off, 01 reduced, 10 intermediate, 11 full.

Top module: `dual_rail_softstart_seq`

## Requirements
- R1: While reset is low, every limit output reads 00 and the post-regulator enable is 0. Leaving reset, the undervoltage lockout is engaged until the rising input-supply flag is seen high.
- R2: With enable high, lockout released and no over-temperature, the off stage moves to ramp: both switch limits 01, post-regulator limit 00, enable 0.
- R3: In ramp, a high negative-start flag moves the machine to hold: both switch limits 10, post-regulator limit 10, enable 1.
- R4: In hold, the machine moves to run (all three limits 11, enable 1) only when both the positive-good and negative-good flags are high.
- R5: In hold, a low negative-start flag returns the machine to ramp, so a persistent rail-to-rail short makes it alternate between ramp and hold.
- R6: In run, losing the positive-good or negative-good flag while negative-start stays high returns the machine to hold. Losing negative-start returns it to ramp.
- R7: The lockout engages when the falling-threshold input flag is low and releases only when the rising-threshold flag is high. Between the two thresholds it keeps its state.
- R8: Over-temperature engages when the trip flag is high and clears only when the release flag is high. Between the two it keeps its state.
- R9: Enable low, lockout or over-temperature forces the off stage, with all limits 00 and enable 0.
- R10: Each input passes through SYNC_STAGES flops. A stage change shows at the outputs on the clock edge after the synchronised flag changes, which is SYNC_STAGES+1 edges after a flag change.
- R11: Limit fields use the fixed encoding 00 off, 01 reduced, 10 intermediate, 11 full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable request |
| vin_rise_ok_i | input | 1 | Input supply above the rising lockout threshold |
| vin_fall_ok_i | input | 1 | Input supply above the falling lockout threshold |
| temp_trip_i | input | 1 | Die temperature at or above the trip point |
| temp_clear_i | input | 1 | Die temperature below the release point |
| neg_start_i | input | 1 | Negative rail past its start threshold |
| neg_good_i | input | 1 | Negative rail at or below its good threshold |
| pos_good_i | input | 1 | Positive rail at or above its good threshold |
| pos_sw_lim_o | output | 2 | Positive switch current-limit selection |
| neg_sw_lim_o | output | 2 | Negative switch current-limit selection |
| ldo_lim_o | output | 2 | Post-regulator current-limit selection |
| ldo_en_o | output | 1 | Post-regulator enable |

## Verification
The main sequence is driven with rail flags that rise one at a time. This shows that hold needs only negative-start, while run needs both good flags together. Single flags are then dropped from run. This separates the step back to hold from the step back to ramp. The input-supply and temperature flags are parked between their two thresholds after each crossing, which shows hysteresis rather than a plain level follow. A toggling negative-start flag, sampled one edge before and on the expected edge, pins both the ramp/hold alternation and the synchroniser latency.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

   typedef enum logic [1:0] {
      LIM_OFF  = 2'b00,
      LIM_LOW  = 2'b01,
      LIM_MID  = 2'b10,
      LIM_FULL = 2'b11
   } lim_e;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_RAMP = 2'd1,
      ST_HOLD = 2'd2,
      ST_RUN  = 2'd3
   } stage_e;

   typedef struct packed {
      lim_e pos_sw;
      lim_e neg_sw;
      lim_e ldo;
      logic ldo_en;
   } drive_t;

   // flag positions inside the synchroniser bus
   localparam int FI_EN    = 0;
   localparam int FI_VRISE = 1;
   localparam int FI_VFALL = 2;
   localparam int FI_TTRIP = 3;
   localparam int FI_TCLR  = 4;
   localparam int FI_NST   = 5;
   localparam int FI_NGD   = 6;
   localparam int FI_PGD   = 7;
   localparam int FLAG_N   = FI_PGD + 1;

   function automatic drive_t stage_drive(stage_e s);
      drive_t d;
      case (s)
         ST_RAMP: d = '{pos_sw: LIM_LOW,  neg_sw: LIM_LOW,  ldo: LIM_OFF,  ldo_en: 1'b0};
         ST_HOLD: d = '{pos_sw: LIM_MID,  neg_sw: LIM_MID,  ldo: LIM_MID,  ldo_en: 1'b1};
         ST_RUN:  d = '{pos_sw: LIM_FULL, neg_sw: LIM_FULL, ldo: LIM_FULL, ldo_en: 1'b1};
         default: d = '{pos_sw: LIM_OFF,  neg_sw: LIM_OFF,  ldo: LIM_OFF,  ldo_en: 1'b0};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rail_flag_sync.sv
module rail_flag_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("rail_flag_sync: WIDTH must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("rail_flag_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q_o = pipe[STAGES-1];
   end

endmodule

// File: rtl/rail_hyst_latch.sv
module rail_hyst_latch #(
   parameter bit RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RESET_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_HYST_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);                                        // R7, R8
   AST_HYST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);                           // R7, R8
   AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));                  // R7, R8

endmodule

// File: rtl/rail_seq_fsm.sv
module rail_seq_fsm
   import rail_seq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en_i,
   input  logic   lock_i,
   input  logic   hot_i,
   input  logic   neg_start_i,
   input  logic   neg_good_i,
   input  logic   pos_good_i,
   output drive_t drv_o
);

   stage_e st, nxt;
   logic   force_off;
   logic   rails_good;

   assign force_off  = !en_i || lock_i || hot_i;
   assign rails_good = pos_good_i && neg_good_i;

   always_comb begin
      nxt = st;
      if (force_off) begin
         nxt = ST_OFF;
      end else begin
         case (st)
            ST_OFF:  nxt = ST_RAMP;
            ST_RAMP: nxt = neg_start_i ? ST_HOLD : ST_RAMP;
            ST_HOLD: nxt = !neg_start_i ? ST_RAMP : (rails_good ? ST_RUN : ST_HOLD);
            ST_RUN:  nxt = !neg_start_i ? ST_RAMP : (rails_good ? ST_RUN : ST_HOLD);
            default: nxt = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= nxt;
   end

   if (REG_OUT) begin : g_reg_out
      drive_t drv_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) drv_q <= stage_drive(ST_OFF);
         else        drv_q <= stage_drive(nxt);
      end
      assign drv_o = drv_q;
   end else begin : g_comb_out
      assign drv_o = stage_drive(st);
   end

   AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      force_off |=> (st == ST_OFF));                                           // R9
   AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && $past(st) != ST_HOLD) |-> $past(neg_start_i));         // R3
   AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_RUN) |-> $past(rails_good));                              // R4
   AST_SHORT_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && !neg_start_i && !force_off) |=> (st == ST_RAMP));      // R5
   AST_RUN_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && neg_start_i && !rails_good && !force_off) |=> (st == ST_HOLD)); // R6
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_OFF) |-> (drv_o.ldo_en == 1'b0 || $past(st) != ST_OFF));      // R9

endmodule

// File: rtl/dual_rail_softstart_seq.sv
module dual_rail_softstart_seq
   import rail_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       vin_rise_ok_i,
   input  logic       vin_fall_ok_i,
   input  logic       temp_trip_i,
   input  logic       temp_clear_i,
   input  logic       neg_start_i,
   input  logic       neg_good_i,
   input  logic       pos_good_i,
   output logic [1:0] pos_sw_lim_o,
   output logic [1:0] neg_sw_lim_o,
   output logic [1:0] ldo_lim_o,
   output logic       ldo_en_o
);

   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("dual_rail_softstart_seq: SYNC_STAGES must lie in 0..4");
   end

   logic [FLAG_N-1:0] raw_flags, flags_s;
   logic              lockout, overtemp;
   drive_t            drv;

   always_comb begin
      raw_flags           = '0;
      raw_flags[FI_EN]    = en_i;
      raw_flags[FI_VRISE] = vin_rise_ok_i;
      raw_flags[FI_VFALL] = vin_fall_ok_i;
      raw_flags[FI_TTRIP] = temp_trip_i;
      raw_flags[FI_TCLR]  = temp_clear_i;
      raw_flags[FI_NST]   = neg_start_i;
      raw_flags[FI_NGD]   = neg_good_i;
      raw_flags[FI_PGD]   = pos_good_i;
   end

   rail_flag_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_flags),
      .q_o   (flags_s)
   );

   // lockout engaged out of reset; set below falling threshold, cleared above rising one
   rail_hyst_latch #(.RESET_VAL(1'b1)) u_uvlo (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (!flags_s[FI_VFALL]),
      .clr_i (flags_s[FI_VRISE]),
      .q_o   (lockout)
   );

   rail_hyst_latch #(.RESET_VAL(1'b0)) u_thermal (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flags_s[FI_TTRIP]),
      .clr_i (flags_s[FI_TCLR]),
      .q_o   (overtemp)
   );

   rail_seq_fsm #(.REG_OUT(REG_OUT)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (flags_s[FI_EN]),
      .lock_i      (lockout),
      .hot_i       (overtemp),
      .neg_start_i (flags_s[FI_NST]),
      .neg_good_i  (flags_s[FI_NGD]),
      .pos_good_i  (flags_s[FI_PGD]),
      .drv_o       (drv)
   );

   assign pos_sw_lim_o = drv.pos_sw;
   assign neg_sw_lim_o = drv.neg_sw;
   assign ldo_lim_o    = drv.ldo;
   assign ldo_en_o     = drv.ldo_en;

   AST_LDO_NEEDS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      ldo_en_o |-> (pos_sw_lim_o >= LIM_MID && neg_sw_lim_o >= LIM_MID));   // R11
   AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      lockout |=> (ldo_en_o == 1'b0 && pos_sw_lim_o == LIM_OFF));          // R7

endmodule

// File: tb/dual_rail_softstart_seq_test.sv
`timescale 1ns/1ps
module dual_rail_softstart_seq_test;

   localparam int SYNC = 2;
   localparam int SETTLE = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 0, vin_rise_ok_i = 0, vin_fall_ok_i = 0, temp_trip_i = 0, temp_clear_i = 0;
   logic neg_start_i = 0, neg_good_i = 0, pos_good_i = 0;
   logic [1:0] pos_sw_lim_o, neg_sw_lim_o, ldo_lim_o;
   logic       ldo_en_o;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   dual_rail_softstart_seq #(.SYNC_STAGES(SYNC)) uut (
      .clk, .rst_n, .en_i, .vin_rise_ok_i, .vin_fall_ok_i, .temp_trip_i, .temp_clear_i,
      .neg_start_i, .neg_good_i, .pos_good_i,
      .pos_sw_lim_o, .neg_sw_lim_o, .ldo_lim_o, .ldo_en_o
   );

   // expected output words {pos, neg, ldo, en}; encoding per R11
   localparam logic [6:0] E_OFF  = 7'b00_00_00_0;
   localparam logic [6:0] E_RAMP = 7'b01_01_00_0;
   localparam logic [6:0] E_HOLD = 7'b10_10_10_1;
   localparam logic [6:0] E_RUN  = 7'b11_11_11_1;

   // vector: flags {en,vrise,vfall,ttrip,tclr,nst,ngd,pgd} then expected word
   localparam int NV = 19;
   localparam logic [14:0] VEC [NV] = '{
      {8'b1010_0000, E_OFF },   // R7 lockout held from reset between thresholds
      {8'b1110_1000, E_RAMP},   // R2
      {8'b1010_1000, E_RAMP},   // R7 between thresholds keeps release
      {8'b1010_1100, E_HOLD},   // R3
      {8'b1010_1101, E_HOLD},   // R4 positive good alone not enough
      {8'b1010_1111, E_RUN },   // R4
      {8'b1010_1110, E_HOLD},   // R6 positive good lost
      {8'b1010_1111, E_RUN },   // R4
      {8'b1010_1000, E_RAMP},   // R6 rails collapse
      {8'b1010_1111, E_RUN },   // R4 full sequence again
      {8'b1011_0111, E_OFF },   // R8 trip
      {8'b1010_0111, E_OFF },   // R8 between temps keeps shutdown
      {8'b1010_1111, E_RUN },   // R8 release
      {8'b1000_1111, E_OFF },   // R7 below falling threshold
      {8'b1010_1111, E_OFF },   // R7 between thresholds keeps lockout
      {8'b1110_1111, E_RUN },   // R7 above rising threshold
      {8'b0110_1111, E_OFF },   // R9 disable
      {8'b1110_1111, E_RUN },   // R9 re-enable
      {8'b1110_1101, E_HOLD}    // R6 negative good lost
   };
   localparam int VREQ [NV] = '{7,2,7,3,4,4,6,4,6,4,8,8,8,7,7,7,9,9,6};

   task automatic drive(input logic [7:0] f);
      {en_i, vin_rise_ok_i, vin_fall_ok_i, temp_trip_i, temp_clear_i,
       neg_start_i, neg_good_i, pos_good_i} = f;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [6:0] exp);
      logic [6:0] got;
      got = {pos_sw_lim_o, neg_sw_lim_o, ldo_lim_o, ldo_en_o};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      drive(8'b1010_0000);
      edges(3);
      check("R1 in reset", E_OFF);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         drive(VEC[v][14:7]);
         edges(SETTLE);
         check($sformatf("R%0d vector %0d", VREQ[v], v), VEC[v][6:0]);
      end

      // R10 latency from enable
      drive(8'b0110_1000);
      edges(SETTLE);
      check("R9 disabled", E_OFF);
      drive(8'b1110_1000);
      edges(SYNC);
      check("R10 before sync edge", E_OFF);
      edges(1);
      check("R10 on sync edge", E_RAMP);

      // R5 short alternation between ramp and hold
      drive(8'b1110_1100);
      edges(SETTLE);
      check("R3 hold", E_HOLD);
      for (int k = 0; k < 2; k++) begin
         drive(8'b1110_1000);
         edges(SYNC);
         check("R10 hold kept before sync", E_HOLD);
         edges(1);
         check("R5 retreat to ramp", E_RAMP);
         drive(8'b1110_1100);
         edges(SYNC + 1);
         check("R5 back to hold", E_HOLD);
      end

      // R6 exact fallback timing
      drive(8'b1110_1111);
      edges(SETTLE);
      check("R4 run", E_RUN);
      drive(8'b1110_1110);
      edges(SYNC);
      check("R6 run before sync", E_RUN);
      edges(1);
      check("R6 fallback to hold", E_HOLD);

      // R1 reset during run, lockout engaged afterwards
      drive(8'b1110_1111);
      edges(SETTLE);
      check("R4 run before reset", E_RUN);
      rst_n = 1'b0;
      #1;
      check("R1 async reset", E_OFF);
      drive(8'b1010_1111);
      @(negedge clk);
      rst_n = 1'b1;
      edges(SETTLE);
      check("R1 lockout after reset", E_OFF);
      drive(8'b1110_1111);
      edges(SETTLE);
      check("R7 release after reset", E_RUN);

      finish_run();
   end

endmodule